// File: doc/BRIEF.md
# AUX Transfer Chunker with Retry

This block turns one request to read or write a range of sink configuration registers into a series of AUX-channel transactions of at most 16 payload bytes. It hands the transactions one at a time to a lower transaction engine over a req/ack/ok handshake, and retries any that fail. When the last transaction is done it reports one overall pass or fail for the whole range.

A failed transaction is retried after a fixed gap of one millisecond. The gap length comes from a clock-frequency parameter given in kHz. When a transaction runs out of attempts it is marked failed, but the remaining transactions are still issued. The overall status is the AND of every transaction's result.

A second start input runs a fixed fetch of the 128-byte display identification block over I2C-over-AUX. The engine reads and writes the caller's data buffer at the byte offset the block provides with each transaction.

Top module: `aux_chunk_xfer`

## Requirements
- R1: A transfer of length L issues ceil(L/16) successful-path transactions; every one carries 16 bytes except the last, which carries L minus 16 times the number before it.
- R2: Transaction k targets the start address plus 16·k (modulo 2^20), uses buffer offset 16·k, and carries the caller's 4-bit command unchanged.
- R3: Each transaction is attempted at most 7 times. The block moves to the next transaction on the first attempt that has ok high at ack, including the 7th attempt.
- R4: After a failed attempt with attempts left, tx_req stays low for exactly CLK_KHZ cycles before the retry. After a success or a final failure, it stays low for exactly one cycle before the next transaction.
- R5: A transaction that fails all 7 attempts does not stop the transfer: the remaining transactions are issued, and pass is the AND of all transaction results.
- R6: A start with length 0 issues no transaction. done is high in the cycle after the start edge, with pass = 1.
- R7: The identification fetch issues, in this order, one write with command 4'b0000, address 0x50, length 1 and tx_zero = 1 (the payload is the byte 0x00), then eight reads with command 4'b0001, address 0x50, length 16 and buffer offsets 0, 16, …, 112, with tx_zero = 0. Every transaction follows the retry rules, and pass is the AND of all nine results.
- R8: Handshake rules:
  - tx_req holds, with cmd, address, length and offset stable, until the engine returns tx_ack.
  - busy is high from the cycle after start until done.
  - done is a one-cycle pulse, and pass holds its value after it.
  - start and id_start are ignored while busy.
- R9: After reset, busy, done, tx_req and pass are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a ranged transfer (sampled when idle) |
| id_start | input | 1 | Begin the identification-block fetch (start wins if both are high) |
| cmd | input | 4 | AUX command passed to every transaction of a ranged transfer |
| addr | input | 20 | Start register address |
| len | input | LEN_W (12) | Transfer length in bytes |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | AND of all transaction results, valid from done |
| tx_req | output | 1 | Transaction request to the engine |
| tx_cmd | output | 4 | Transaction command |
| tx_addr | output | 20 | Transaction address |
| tx_len | output | 5 | Transaction payload length, 1 to 16 |
| tx_off | output | LEN_W (12) | Byte offset into the caller's data buffer |
| tx_zero | output | 1 | Payload is the literal byte 0x00 instead of buffer data |
| tx_ack | input | 1 | Engine finished the current attempt (one cycle) |
| tx_ok | input | 1 | Attempt result, valid with tx_ack |

## Verification
The engine model answers each request two cycles after it sees it, and logs the request fields together with the number of cycles tx_req was low before it. The gap after a failed attempt must therefore equal CLK_KHZ exactly, and the gap before a new transaction must equal one cycle, since tx_req falls at the acknowledging edge. A zero-length start must show done at the first sample after the start edge. Every other result is read once done has been seen: pass, plus the complete request log compared against the addresses, lengths, offsets and attempt counts worked out from the length and the failure plan.

// File: rtl/aux_chunk_xfer.sv
module aux_chunk_xfer #(
  parameter int ADDR_W   = 20,
  parameter int LEN_W    = 12,
  parameter int CHUNK    = 16,
  parameter int TRIES    = 7,
  parameter int CLK_KHZ  = 100000,
  parameter int ID_DEV   = 'h50,
  parameter int ID_BYTES = 128
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          id_start,
  input  logic [3:0]                    cmd,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [LEN_W-1:0]              len,
  output logic                          busy,
  output logic                          done,
  output logic                          pass,
  output logic                          tx_req,
  output logic [3:0]                    tx_cmd,
  output logic [ADDR_W-1:0]             tx_addr,
  output logic [$clog2(CHUNK+1)-1:0]    tx_len,
  output logic [LEN_W-1:0]              tx_off,
  output logic                          tx_zero,
  input  logic                          tx_ack,
  input  logic                          tx_ok
);
  localparam int CLEN_W  = $clog2(CHUNK + 1);
  localparam int TRY_W   = $clog2(TRIES + 1);
  localparam int GAP_CYC = CLK_KHZ;
  localparam int GAP_W   = $clog2(GAP_CYC + 1);
  localparam logic [3:0] I2C_WR = 4'b0000;
  localparam logic [3:0] I2C_RD = 4'b0001;

  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_WAIT, S_STEP, S_FIN} st_t;

  st_t               st;
  logic              id_mode, id_wr, ok_r;
  logic [3:0]        cmd_r;
  logic [ADDR_W-1:0] base_r;
  logic [LEN_W-1:0]  off_r, rem_r;
  logic [TRY_W-1:0]  tries_r;
  logic [GAP_W-1:0]  gap_r;

  logic [CLEN_W-1:0] clen;
  logic [LEN_W-1:0]  rem_nx;
  logic              last;

  assign clen   = id_wr ? CLEN_W'(1)
                : (rem_r >= LEN_W'(CHUNK)) ? CLEN_W'(CHUNK) : CLEN_W'(rem_r);
  assign rem_nx = rem_r - LEN_W'(clen);
  assign last   = !id_wr && (rem_nx == '0);

  assign tx_req  = (st == S_ISSUE);
  assign tx_cmd  = id_mode ? (id_wr ? I2C_WR : I2C_RD) : cmd_r;
  assign tx_addr = id_mode ? ADDR_W'(ID_DEV) : base_r + ADDR_W'(off_r);
  assign tx_len  = clen;
  assign tx_off  = off_r;
  assign tx_zero = id_wr;
  assign busy    = (st != S_IDLE);
  assign done    = (st == S_FIN);
  assign pass    = ok_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      id_mode <= 1'b0;
      id_wr   <= 1'b0;
      ok_r    <= 1'b0;
      cmd_r   <= '0;
      base_r  <= '0;
      off_r   <= '0;
      rem_r   <= '0;
      tries_r <= '0;
      gap_r   <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (start) begin
            id_mode <= 1'b0;
            id_wr   <= 1'b0;
            cmd_r   <= cmd;
            base_r  <= addr;
            off_r   <= '0;
            rem_r   <= len;
            tries_r <= '0;
            ok_r    <= 1'b1;
            st      <= (len == '0) ? S_FIN : S_ISSUE;
          end else if (id_start) begin
            id_mode <= 1'b1;
            id_wr   <= 1'b1;
            off_r   <= '0;
            rem_r   <= LEN_W'(ID_BYTES);
            tries_r <= '0;
            ok_r    <= 1'b1;
            st      <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          if (tx_ack) begin
            if (tx_ok) begin
              st <= S_STEP;
            end else if (tries_r == TRY_W'(TRIES - 1)) begin
              ok_r <= 1'b0;
              st   <= S_STEP;
            end else begin
              tries_r <= tries_r + 1'b1;
              gap_r   <= '0;
              st      <= S_WAIT;
            end
          end
        end
        S_WAIT: begin
          if (gap_r == GAP_W'(GAP_CYC - 1)) st <= S_ISSUE;
          else                              gap_r <= gap_r + 1'b1;
        end
        S_STEP: begin
          tries_r <= '0;
          if (id_wr) begin
            id_wr <= 1'b0;
          end else begin
            off_r <= off_r + LEN_W'(CHUNK);
            rem_r <= rem_nx;
          end
          st <= last ? S_FIN : S_ISSUE;
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && !tx_ack |=> tx_req && $stable(tx_addr) && $stable(tx_len)
                          && $stable(tx_cmd) && $stable(tx_off)); // R8
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> (tx_len != '0) && (tx_len <= CLEN_W'(CHUNK))); // R1
  AST_RETRY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && tx_ack && !tx_ok && (tries_r != TRY_W'(TRIES - 1)) |=> !tx_req && busy); // R4
  AST_TRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> tries_r < TRY_W'(TRIES)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R8
  AST_ZERO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && (len == '0) |=> done && !tx_req && pass); // R6
endmodule

// File: tb/aux_chunk_xfer_tb_top.sv
module aux_chunk_xfer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int GAP        = 5;
  localparam int LAT        = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, id_start = 1'b0;
  logic [3:0]  cmd = '0;
  logic [19:0] addr = '0;
  logic [11:0] len = '0;
  logic        busy, done, pass, tx_req, tx_zero;
  logic [3:0]  tx_cmd;
  logic [19:0] tx_addr;
  logic [4:0]  tx_len;
  logic [11:0] tx_off;
  logic        tx_ack = 1'b0, tx_ok = 1'b0;

  aux_chunk_xfer #(.CLK_KHZ(GAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .id_start(id_start),
    .cmd(cmd), .addr(addr), .len(len),
    .busy(busy), .done(done), .pass(pass),
    .tx_req(tx_req), .tx_cmd(tx_cmd), .tx_addr(tx_addr), .tx_len(tx_len),
    .tx_off(tx_off), .tx_zero(tx_zero), .tx_ack(tx_ack), .tx_ok(tx_ok)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int ncyc = 0;
  always @(posedge clk) ncyc++;

  int total = 0, bad = 0;
  logic [3:0]  lg_cmd [64];
  logic [19:0] lg_addr[64];
  int          lg_len [64], lg_off[64], lg_gap[64];
  bit          lg_zero[64];
  int nlog = 0, ch = 0, att = 0, wcnt = 0, rise_c = 0, last_fall = 0;
  int fail_plan[16];
  bit prev_req = 0;
  int done_lat = 0;

  always @(negedge clk) begin
    if (tx_ack) begin
      tx_ack = 1'b0; tx_ok = 1'b0;
    end else if (tx_req) begin
      if (!prev_req) rise_c = ncyc;
      if (wcnt == LAT) begin
        if (nlog < 64) begin
          lg_cmd[nlog] = tx_cmd; lg_addr[nlog] = tx_addr; lg_len[nlog] = int'(tx_len);
          lg_off[nlog] = int'(tx_off); lg_zero[nlog] = tx_zero; lg_gap[nlog] = rise_c - last_fall;
        end
        nlog++;
        att++;
        tx_ok  = (ch < 16) ? (att > fail_plan[ch]) : 1'b1;
        tx_ack = 1'b1;
        if (tx_ok || att == 7) begin ch++; att = 0; end
        wcnt = 0;
      end else wcnt++;
    end
    if (!tx_req && prev_req) last_fall = ncyc;
    prev_req = tx_req;
  end

  task automatic check(input bit cond, input string tag, input longint act, input longint exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    nlog = 0; ch = 0; att = 0;
    for (int i = 0; i < 16; i++) fail_plan[i] = 0;
  endtask

  task automatic run(input bit is_id, input logic [3:0] c, input logic [19:0] a,
                     input logic [11:0] l, input int poke_at);
    int n;
    @(negedge clk);
    cmd = c; addr = a; len = l;
    if (is_id) id_start = 1'b1; else start = 1'b1;
    @(negedge clk);
    start = 1'b0; id_start = 1'b0;
    check(busy || done, "R8 busy after start", busy, 1);
    n = 1;
    while (!done && n < 20000) begin
      if (n == poke_at) begin
        start = 1'b1; id_start = 1'b1; addr = 20'hAAAAA; len = 12'd16; cmd = 4'hF;
      end else begin
        start = 1'b0; id_start = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start = 1'b0; id_start = 1'b0;
    done_lat = n;
    check(done, "R8 done reached", done, 1);
  endtask

  task automatic check_plain(input logic [3:0] c, input logic [19:0] a, input int l, input string tag);
    int n = (l + 15) / 16;
    check(nlog == n, {tag, " request count"}, nlog, n);
    for (int k = 0; k < n && k < nlog; k++) begin
      int el = (k == n - 1) ? l - 16 * (n - 1) : 16;
      logic [19:0] ea = a + 20'(16 * k);
      check(lg_addr[k] == ea, "R2 chunk address", lg_addr[k], ea);
      check(lg_len[k] == el, "R1 chunk length", lg_len[k], el);
      check(lg_off[k] == 16 * k, "R2 buffer offset", lg_off[k], 16 * k);
      check(lg_cmd[k] == c, "R2 command", lg_cmd[k], c);
      if (k > 0) check(lg_gap[k] == 1, "R4 gap between chunks", lg_gap[k], 1);
    end
  endtask

  task automatic t_reset();
    check(!busy, "R9 busy at reset", busy, 0);
    check(!done, "R9 done at reset", done, 0);
    check(!tx_req, "R9 req at reset", tx_req, 0);
    check(!pass, "R9 pass at reset", pass, 0);
  endtask

  task automatic t_plain();
    clear_log(); run(0, 4'h9, 20'h12340, 12'd40, -1);
    check_plain(4'h9, 20'h12340, 40, "R1");
    check(pass, "R5 pass all ok", pass, 1);
    @(negedge clk); check(!done && !busy, "R8 done single pulse", done, 0);
    clear_log(); run(0, 4'h8, 20'h00100, 12'd32, -1);
    check_plain(4'h8, 20'h00100, 32, "R1 exact multiple");
    clear_log(); run(0, 4'h9, 20'h00200, 12'd1, -1);
    check_plain(4'h9, 20'h00200, 1, "R1 single byte");
  endtask

  task automatic t_wrap();
    clear_log(); run(0, 4'h9, 20'hFFFF8, 12'd20, -1);
    check_plain(4'h9, 20'hFFFF8, 20, "R2 wrap");
  endtask

  task automatic t_retry();
    clear_log(); fail_plan[1] = 2;
    run(0, 4'h9, 20'h00300, 12'd48, -1);
    check(nlog == 5, "R3 attempts with retries", nlog, 5);
    for (int i = 1; i <= 3; i++) check(lg_addr[i] == 20'h00310, "R3 retry same address", lg_addr[i], 20'h00310);
    check(lg_gap[2] == GAP, "R4 retry gap", lg_gap[2], GAP);
    check(lg_gap[3] == GAP, "R4 retry gap", lg_gap[3], GAP);
    check(lg_gap[4] == 1, "R4 gap after success", lg_gap[4], 1);
    check(lg_addr[4] == 20'h00320, "R3 moves on after success", lg_addr[4], 20'h00320);
    check(pass, "R5 pass after recovered retry", pass, 1);
  endtask

  task automatic t_exhaust();
    clear_log(); fail_plan[0] = 7;
    run(0, 4'h9, 20'h00400, 12'd40, -1);
    check(nlog == 9, "R5 remaining chunks issued", nlog, 9);
    for (int i = 0; i < 7; i++) check(lg_addr[i] == 20'h00400, "R3 seven attempts", lg_addr[i], 20'h00400);
    for (int i = 1; i < 7; i++) check(lg_gap[i] == GAP, "R4 retry gap", lg_gap[i], GAP);
    check(lg_gap[7] == 1, "R4 gap after final failure", lg_gap[7], 1);
    check(lg_addr[7] == 20'h00410, "R5 next chunk address", lg_addr[7], 20'h00410);
    check(lg_len[8] == 8, "R5 last chunk length", lg_len[8], 8);
    check(!pass, "R5 pass is AND", pass, 0);
    clear_log(); fail_plan[2] = 6;
    run(0, 4'h9, 20'h00500, 12'd48, -1);
    check(nlog == 9, "R3 success on seventh attempt", nlog, 9);
    check(pass, "R3 seventh attempt counts", pass, 1);
  endtask

  task automatic t_zero();
    clear_log(); run(0, 4'h9, 20'h00600, 12'd0, -1);
    check(done_lat == 1, "R6 done next cycle", done_lat, 1);
    check(pass, "R6 pass on zero length", pass, 1);
    repeat (3) @(negedge clk);
    check(nlog == 0, "R6 no transactions", nlog, 0);
  endtask

  task automatic t_ident();
    clear_log(); fail_plan[0] = 1;
    run(1, 4'h9, 20'h00000, 12'd0, -1);
    check(nlog == 10, "R7 request count", nlog, 10);
    for (int i = 0; i < 2; i++) begin
      check(lg_cmd[i] == 4'h0 && lg_addr[i] == 20'h50, "R7 write cmd/addr", {lg_cmd[i], lg_addr[i]}, 24'h000050);
      check(lg_len[i] == 1 && lg_zero[i], "R7 write length and zero byte", lg_len[i], 1);
    end
    for (int k = 0; k < 8; k++) begin
      int j = k + 2;
      check(lg_cmd[j] == 4'h1 && lg_addr[j] == 20'h50, "R7 read cmd/addr", {lg_cmd[j], lg_addr[j]}, 24'h100050);
      check(lg_len[j] == 16 && !lg_zero[j], "R7 read length", lg_len[j], 16);
      check(lg_off[j] == 16 * k, "R7 read buffer offset", lg_off[j], 16 * k);
    end
    check(pass, "R7 pass", pass, 1);
    clear_log(); fail_plan[4] = 7;
    run(1, 4'h9, 20'h00000, 12'd0, -1);
    check(nlog == 15, "R7 failed read continues", nlog, 15);
    check(!pass, "R7 pass is AND", pass, 0);
  endtask

  task automatic t_busy_start();
    clear_log(); run(0, 4'h9, 20'h00700, 12'd40, 4);
    repeat (12) @(negedge clk);
    check_plain(4'h9, 20'h00700, 40, "R8 start ignored while busy");
    check(!busy, "R8 idle after ignored start", busy, 0);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R8 act=%0d exp=%0d", ncyc, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_wrap();
    t_retry();
    t_exhaust();
    t_zero();
    t_ident();
    t_busy_start();
    summary();
    $finish;
  end
endmodule